// File: doc/BRIEF.md
# Dual-Clock Asynchronous FIFO

This block carries a stream of data words from a producer running on one clock to a consumer running on an unrelated clock. Each side keeps its own binary pointer. It hands a Gray-coded copy of that pointer to the other side through a flip-flop chain whose length is a parameter. Each side subtracts the pointer it receives from its own pointer to get a local word count. Its flags and level output come from that count.

The write side makes the write-full flag, which is the one to trust before writing. It also makes a write-empty flag and a write level count, both for information only. The read side makes the read-empty flag, which is the one to trust before reading, plus a read-full flag and a read level count. Each level count passes through its own configurable register pipeline, which adds latency and nothing else.

The synchronizer-length parameters are written as the number of stages plus two. A value of 4 gives two flip-flops, which is the least that protects against metastability. A read-mode parameter picks one of two behaviours. In normal mode, a word is loaded into the output register by the read edge that accepts a request. In look-ahead mode, the head word is already on the output. Optional guards ignore writes while full and reads while empty. Another option holds the write side in reset until two write-clock edges after the asynchronous clear releases. The read side always releases its reset this way.

Top module: `afifo_dc`

## Requirements
- R1: While `clr_n` is low, both domains show `wr_empty`=1, `rd_empty`=1, `wr_full`=0, `rd_full`=0, and `wr_level`=`rd_level`=0. They stay in that state after release until a write takes place.
- R2: In normal mode, words leave in the order they were written. `rd_data` takes the head word on the read-clock edge that accepts `rd_req`.
- R3: With `OVF_GUARD`=1, a write requested while `wr_full` is high is ignored. The stored words and the count are unchanged.
- R4: With `UNF_GUARD`=1, a read requested while `rd_empty` is high is ignored. The read pointer and the count are unchanged.
- R5: `wr_full` rises right after the write edge that brings the count to 2^`ADDR_W`. `wr_level` shows the count `WR_LVL_DLY` write edges after the count changes.
- R6: After a write into an empty FIFO, `rd_empty` falls exactly `W2R_SYNC`-2 read-clock edges after the accepting write edge.
- R7: After a read from a full FIFO, `wr_full` falls exactly `R2W_SYNC`-2 write-clock edges after the accepting read edge.
- R8: `rd_level` shows the read-side count `RD_LVL_DLY` read edges after that count changes.
- R9: In look-ahead mode (`RD_MODE`=`RD_LOOKAHEAD`), the head word is on `rd_data` while `rd_empty` is low, with no request. The read edge that accepts a request moves the next word onto `rd_data`.
- R10: Once all pointer updates have crossed, `rd_full` is 1 when 2^`ADDR_W` words are stored, and `wr_empty` is 1 when none are stored.
- R11: With `CLR_SYNC_WR`=1, write requests seen on the first two write-clock edges after `clr_n` rises are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clr_n | input | 1 | Asynchronous active-low clear for both domains |
| wr_clk | input | 1 | Write-domain clock |
| wr_req | input | 1 | Write request |
| wr_data | input | DATA_W | Word to write |
| wr_full | output | 1 | FIFO full, write domain (authoritative) |
| wr_empty | output | 1 | FIFO empty as seen by the write domain |
| wr_level | output | ADDR_W+1 | Stored-word count, write domain, pipelined |
| rd_clk | input | 1 | Read-domain clock |
| rd_req | input | 1 | Read request |
| rd_data | output | DATA_W | Read word (registered or look-ahead) |
| rd_full | output | 1 | FIFO full as seen by the read domain |
| rd_empty | output | 1 | FIFO empty, read domain (authoritative) |
| rd_level | output | ADDR_W+1 | Stored-word count, read domain, pipelined |

## Verification
The assertions assume that each request is sampled only on its own clock, and that neither domain comes out of reset with a request already being taken. The latency checks also assume that no write edge lands exactly on a read edge. If the edges coincided, the pointer would reach the other side one stage early or late. The stimulus changes every input on the falling edge of its own clock. The two clock periods are chosen so their rising edges never coincide, so every crossing delay has one exact expected count.

// File: rtl/afifo_pkg.sv
package afifo_pkg;

  typedef enum logic { RD_NORMAL = 1'b0, RD_LOOKAHEAD = 1'b1 } rd_mode_e;

  function automatic logic [31:0] bin_to_gray(input logic [31:0] b);
    return b ^ (b >> 1);
  endfunction

  function automatic logic [31:0] gray_to_bin(input logic [31:0] g);
    logic [31:0] b;
    b[31] = g[31];
    for (int i = 30; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

endpackage

// File: rtl/afifo_pipe.sv
// Register chain with asynchronous clear; N = 0 gives a wire.
module afifo_pipe #(
  parameter int W = 1,
  parameter int N = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  if (N == 0) begin : g_wire
    assign q = d;
  end else begin : g_reg
    logic [W-1:0] stg_q [N];
    logic [W-1:0] stg_d [N];

    always_comb begin
      stg_d[0] = d;
      for (int i = 1; i < N; i++) stg_d[i] = stg_q[i-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        for (int i = 0; i < N; i++) stg_q[i] <= '0;
      end else begin
        for (int i = 0; i < N; i++) stg_q[i] <= stg_d[i];
      end
    end

    assign q = stg_q[N-1];
  end

endmodule

// File: rtl/afifo_mem.sv
// Storage array: write port on the write clock, read port registered or look-ahead.
module afifo_mem #(
  parameter int DW        = 8,
  parameter int AW        = 4,
  parameter bit LOOKAHEAD = 1'b0
) (
  input  logic          wclk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          rclk,
  input  logic          rrst_n,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);

  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge wclk) begin
    if (we) mem[waddr] <= wdata;
  end

  if (LOOKAHEAD) begin : g_ahead
    assign rdata = mem[raddr];
  end else begin : g_normal
    logic [DW-1:0] rdata_q;
    always_ff @(posedge rclk or negedge rrst_n) begin
      if (!rrst_n)  rdata_q <= '0;
      else if (re)  rdata_q <= mem[raddr];
    end
    assign rdata = rdata_q;
  end

endmodule

// File: rtl/afifo_dc.sv
module afifo_dc
  import afifo_pkg::*;
#(
  parameter int       DATA_W      = 8,
  parameter int       ADDR_W      = 4,
  parameter int       W2R_SYNC    = 4,
  parameter int       R2W_SYNC    = 4,
  parameter int       WR_LVL_DLY  = 1,
  parameter int       RD_LVL_DLY  = 1,
  parameter rd_mode_e RD_MODE     = RD_NORMAL,
  parameter bit       CLR_SYNC_WR = 1'b1,
  parameter bit       OVF_GUARD   = 1'b1,
  parameter bit       UNF_GUARD   = 1'b1
) (
  input  logic              clr_n,
  input  logic              wr_clk,
  input  logic              wr_req,
  input  logic [DATA_W-1:0] wr_data,
  output logic              wr_full,
  output logic              wr_empty,
  output logic [ADDR_W:0]   wr_level,
  input  logic              rd_clk,
  input  logic              rd_req,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_full,
  output logic              rd_empty,
  output logic [ADDR_W:0]   rd_level
);

  localparam int PW     = ADDR_W + 1;
  localparam int DEPTH  = 1 << ADDR_W;
  localparam int W2R_ST = W2R_SYNC - 2;
  localparam int R2W_ST = R2W_SYNC - 2;

  // ---------------- reset release ----------------
  logic wr_rst_n, rd_rst_n;

  afifo_pipe #(.W(1), .N(2)) u_rd_rst (
    .clk(rd_clk), .rst_n(clr_n), .d(1'b1), .q(rd_rst_n));

  if (CLR_SYNC_WR) begin : g_wr_rst_sync
    afifo_pipe #(.W(1), .N(2)) u_wr_rst (
      .clk(wr_clk), .rst_n(clr_n), .d(1'b1), .q(wr_rst_n));
  end else begin : g_wr_rst_direct
    assign wr_rst_n = clr_n;
  end

  // ---------------- write domain ----------------
  logic [PW-1:0] wbin_q, wbin_d, wgray_q, wgray_d;
  logic [PW-1:0] rgray_w, rbin_w, wcount;
  logic          wr_accept;

  assign wr_accept = wr_req && (!wr_full || !OVF_GUARD);

  always_comb begin
    wbin_d  = wbin_q + PW'(wr_accept);
    wgray_d = PW'(bin_to_gray(32'(wbin_d)));
  end

  always_ff @(posedge wr_clk or negedge wr_rst_n) begin
    if (!wr_rst_n) begin
      wbin_q  <= '0;
      wgray_q <= '0;
    end else if (wr_accept) begin
      wbin_q  <= wbin_d;
      wgray_q <= wgray_d;
    end
  end

  logic [PW-1:0] rgray_q;

  afifo_pipe #(.W(PW), .N(R2W_ST)) u_r2w (
    .clk(wr_clk), .rst_n(wr_rst_n), .d(rgray_q), .q(rgray_w));

  assign rbin_w   = PW'(gray_to_bin(32'(rgray_w)));
  assign wcount   = wbin_q - rbin_w;
  assign wr_full  = (wcount == PW'(DEPTH));
  assign wr_empty = (wcount == '0);

  afifo_pipe #(.W(PW), .N(WR_LVL_DLY)) u_wlvl (
    .clk(wr_clk), .rst_n(wr_rst_n), .d(wcount), .q(wr_level));

  // ---------------- read domain ----------------
  logic [PW-1:0] rbin_q, rbin_d, rgray_d;
  logic [PW-1:0] wgray_r, wbin_r, rcount;
  logic          rd_accept;

  assign rd_accept = rd_req && (!rd_empty || !UNF_GUARD);

  always_comb begin
    rbin_d  = rbin_q + PW'(rd_accept);
    rgray_d = PW'(bin_to_gray(32'(rbin_d)));
  end

  always_ff @(posedge rd_clk or negedge rd_rst_n) begin
    if (!rd_rst_n) begin
      rbin_q  <= '0;
      rgray_q <= '0;
    end else if (rd_accept) begin
      rbin_q  <= rbin_d;
      rgray_q <= rgray_d;
    end
  end

  afifo_pipe #(.W(PW), .N(W2R_ST)) u_w2r (
    .clk(rd_clk), .rst_n(rd_rst_n), .d(wgray_q), .q(wgray_r));

  assign wbin_r   = PW'(gray_to_bin(32'(wgray_r)));
  assign rcount   = wbin_r - rbin_q;
  assign rd_empty = (rcount == '0);
  assign rd_full  = (rcount == PW'(DEPTH));

  afifo_pipe #(.W(PW), .N(RD_LVL_DLY)) u_rlvl (
    .clk(rd_clk), .rst_n(rd_rst_n), .d(rcount), .q(rd_level));

  // ---------------- storage ----------------
  afifo_mem #(.DW(DATA_W), .AW(ADDR_W), .LOOKAHEAD(RD_MODE == RD_LOOKAHEAD)) u_mem (
    .wclk(wr_clk), .we(wr_accept), .waddr(wbin_q[ADDR_W-1:0]), .wdata(wr_data),
    .rclk(rd_clk), .rrst_n(rd_rst_n), .re(rd_accept),
    .raddr(rbin_q[ADDR_W-1:0]), .rdata(rd_data));

  // ---------------- assertions ----------------
  if (OVF_GUARD) begin : g_ovf_chk
    // R3: a write while full leaves the write pointer alone
    a_r3_no_overflow: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
      (wr_req && wr_full) |=> $stable(wbin_q));
  end

  if (UNF_GUARD) begin : g_unf_chk
    // R4: a read while empty leaves the read pointer alone
    a_r4_no_underflow: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
      (rd_req && rd_empty) |=> $stable(rbin_q));
  end

  // R5: the write-side count never exceeds the depth
  a_r5_wcount_bound: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
    wcount <= PW'(DEPTH));

  // R6: the pointer sent to the read side changes by at most one bit per write edge
  a_r6_wgray_step: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
    $countones(wgray_q ^ $past(wgray_q)) <= 1);

  // R7: the pointer sent to the write side changes by at most one bit per read edge
  a_r7_rgray_step: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
    $countones(rgray_q ^ $past(rgray_q)) <= 1);

  // R8: the pipelined read level never exceeds the depth
  a_r8_rlevel_bound: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
    rd_level <= PW'(DEPTH));

endmodule

// File: tb/test_afifo_dc.sv
`timescale 1ns/100ps
module test_afifo_dc;
  import afifo_pkg::*;

  localparam int DW = 8;
  localparam int AW = 3;
  localparam int DEPTH = 1 << AW;
  localparam int W2R = 4;   // two stages
  localparam int R2W = 5;   // three stages
  localparam int WLD = 1;
  localparam int RLD = 2;

  logic clr_n = 1'b0;
  logic wr_clk = 1'b0, rd_clk = 1'b0;
  logic wr_req = 1'b0, rd_req = 1'b0;
  logic [DW-1:0] wr_data = '0;
  logic wr_full, wr_empty, rd_full, rd_empty;
  logic [AW:0] wr_level, rd_level;
  logic [DW-1:0] rd_data;

  logic wr_req2 = 1'b0, rd_req2 = 1'b0;
  logic [DW-1:0] wr_data2 = '0;
  logic wr_full2, wr_empty2, rd_full2, rd_empty2;
  logic [AW:0] wr_level2, rd_level2;
  logic [DW-1:0] rd_data2;

  always #5   wr_clk = ~wr_clk;   // 100 MHz
  always #7.3 rd_clk = ~rd_clk;   // rising edges never meet the write clock's

  afifo_dc #(.DATA_W(DW), .ADDR_W(AW), .W2R_SYNC(W2R), .R2W_SYNC(R2W),
             .WR_LVL_DLY(WLD), .RD_LVL_DLY(RLD), .RD_MODE(RD_NORMAL)) i_afifo_dc (
    .clr_n(clr_n), .wr_clk(wr_clk), .wr_req(wr_req), .wr_data(wr_data),
    .wr_full(wr_full), .wr_empty(wr_empty), .wr_level(wr_level),
    .rd_clk(rd_clk), .rd_req(rd_req), .rd_data(rd_data),
    .rd_full(rd_full), .rd_empty(rd_empty), .rd_level(rd_level));

  afifo_dc #(.DATA_W(DW), .ADDR_W(AW), .W2R_SYNC(W2R), .R2W_SYNC(R2W),
             .WR_LVL_DLY(WLD), .RD_LVL_DLY(RLD), .RD_MODE(RD_LOOKAHEAD)) i_afifo_dc_la (
    .clr_n(clr_n), .wr_clk(wr_clk), .wr_req(wr_req2), .wr_data(wr_data2),
    .wr_full(wr_full2), .wr_empty(wr_empty2), .wr_level(wr_level2),
    .rd_clk(rd_clk), .rd_req(rd_req2), .rd_data(rd_data2),
    .rd_full(rd_full2), .rd_empty(rd_empty2), .rd_level(rd_level2));

  int n_chk = 0, n_bad = 0;
  logic [DW-1:0] model [$];

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  task automatic push(input logic [DW-1:0] d);
    @(negedge wr_clk); wr_req = 1'b1; wr_data = d;
    @(negedge wr_clk); wr_req = 1'b0;
  endtask

  task automatic pop(output logic [DW-1:0] d);
    @(negedge rd_clk); rd_req = 1'b1;
    @(negedge rd_clk); rd_req = 1'b0; d = rd_data;
  endtask

  task automatic settle();
    repeat (12) @(negedge wr_clk);
    repeat (12) @(negedge rd_clk);
  endtask

  task automatic do_clear();
    @(negedge wr_clk); clr_n = 1'b0;
    repeat (3) @(negedge rd_clk);
    @(negedge wr_clk); clr_n = 1'b1;
    settle();
    model.delete();
  endtask

  // R1
  task automatic t_reset();
    @(negedge wr_clk); clr_n = 1'b0; #1;
    check("R1 wr_empty in clear", int'(wr_empty), 1);
    check("R1 rd_empty in clear", int'(rd_empty), 1);
    check("R1 wr_full in clear", int'(wr_full), 0);
    check("R1 rd_full in clear", int'(rd_full), 0);
    check("R1 levels in clear", int'(wr_level) + int'(rd_level), 0);
    @(negedge wr_clk); clr_n = 1'b1;
    settle();
    check("R1 rd_empty after release", int'(rd_empty), 1);
    check("R1 wr_level after release", int'(wr_level), 0);
  endtask

  // R6
  task automatic t_empty_latency();
    int n;
    @(negedge wr_clk); wr_req = 1'b1; wr_data = 8'hA1; model.push_back(8'hA1);
    @(posedge wr_clk);
    fork begin @(negedge wr_clk); wr_req = 1'b0; end join_none
    n = 0;
    for (int k = 0; k < 20; k++) begin
      @(posedge rd_clk); n++;
      @(negedge rd_clk);
      if (!rd_empty) break;
    end
    check("R6 read edges until rd_empty falls", n, W2R - 2);
    settle();
  endtask

  // R5, R3, R10, R7, R8, R2
  task automatic t_fill_drain();
    logic [DW-1:0] d;
    int n;
    for (int i = 1; i < DEPTH; i++) begin
      d = DW'(8'h10 + i * 8'h13);
      push(d); model.push_back(d);
      if (i == DEPTH - 2) check("R5 wr_full one short of depth", int'(wr_full), 0);
    end
    check("R5 wr_full right after filling edge", int'(wr_full), 1);
    check("R5 wr_level one edge behind", int'(wr_level), DEPTH - 1);
    @(negedge wr_clk);
    check("R5 wr_level after delay", int'(wr_level), DEPTH);
    push(8'hEE); push(8'hEF);
    settle();
    check("R3 wr_level after blocked writes", int'(wr_level), DEPTH);
    check("R3 wr_full held", int'(wr_full), 1);
    check("R10 rd_full when full", int'(rd_full), 1);
    check("R8 rd_level when full", int'(rd_level), DEPTH);
    check("R10 wr_empty when full", int'(wr_empty), 0);
    // R7: read one word, count write edges until wr_full falls
    @(negedge rd_clk); rd_req = 1'b1;
    @(posedge rd_clk);
    fork begin @(negedge rd_clk); rd_req = 1'b0; end join_none
    n = 0;
    for (int k = 0; k < 20; k++) begin
      @(posedge wr_clk); n++;
      @(negedge wr_clk);
      if (!wr_full) break;
    end
    check("R7 write edges until wr_full falls", n, R2W - 2);
    check("R2 first word out", int'(rd_data), int'(model.pop_front()));
    settle();
    // R8: level latency of RLD read edges
    check("R8 rd_level settled", int'(rd_level), DEPTH - 1);
    pop(d);
    check("R2 second word out", int'(d), int'(model.pop_front()));
    check("R8 rd_level right after read", int'(rd_level), DEPTH - 1);
    @(negedge rd_clk);
    check("R8 rd_level one edge later", int'(rd_level), DEPTH - 1);
    @(negedge rd_clk);
    check("R8 rd_level after delay", int'(rd_level), DEPTH - 2);
    while (model.size() > 0) begin
      pop(d);
      check("R2 and R3 drained word", int'(d), int'(model.pop_front()));
    end
    settle();
    check("R3 nothing extra stored", int'(rd_empty), 1);
    check("R10 wr_empty when drained", int'(wr_empty), 1);
    check("R10 rd_full when drained", int'(rd_full), 0);
  endtask

  // R4
  task automatic t_underflow();
    logic [DW-1:0] d;
    pop(d); pop(d);
    settle();
    check("R4 rd_level after blocked reads", int'(rd_level), 0);
    check("R4 wr_level after blocked reads", int'(wr_level), 0);
    push(8'h5A);
    settle();
    check("R4 rd_level after one write", int'(rd_level), 1);
    pop(d);
    check("R4 word after blocked reads", int'(d), 8'h5A);
  endtask

  // R9
  task automatic t_lookahead();
    for (int i = 0; i < 3; i++) begin
      @(negedge wr_clk); wr_req2 = 1'b1; wr_data2 = DW'(8'hC0 + i);
      @(negedge wr_clk); wr_req2 = 1'b0;
    end
    settle();
    check("R9 head word shown without request", int'(rd_data2), 8'hC0);
    @(negedge rd_clk); rd_req2 = 1'b1;
    @(negedge rd_clk); rd_req2 = 1'b0;
    check("R9 next word after accept", int'(rd_data2), 8'hC1);
    @(negedge rd_clk);
    check("R9 word held without request", int'(rd_data2), 8'hC1);
  endtask

  // R11
  task automatic t_clear_release();
    @(negedge wr_clk); clr_n = 1'b0;
    wr_req = 1'b1; wr_data = 8'h33;
    repeat (3) @(negedge wr_clk);
    clr_n = 1'b1;
    @(posedge wr_clk); @(posedge wr_clk);
    @(negedge wr_clk); wr_req = 1'b0;
    settle();
    check("R11 no write near clear release (rd_empty)", int'(rd_empty), 1);
    check("R11 no write near clear release (wr_level)", int'(wr_level), 0);
  endtask

  initial begin
    t_reset();
    t_empty_latency();
    t_fill_drain();
    t_underflow();
    do_clear();
    t_lookahead();
    t_clear_release();
    finish_run();
  end

  initial begin
    #1ms;
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

endmodule